// File: doc/BRIEF.md
# System NMI Status and Control Port

This block is an 8-bit system control and status register that sits at one I/O address. It watches two error sources. The first is a system-error pulse that a bus device or the memory subsystem drives active-low. The second is a channel-check line that an expansion card holds active-low. Each source has a sticky status bit, and the block raises a registered NMI request while either status bit is set.

The same register shows the live level of timer channel 2 and a bit that toggles once per completed refresh cycle. Its low nibble is a write/read-back control field. Software enables each error source by writing 0 to its control bit. Writing 1 to that bit clears the source's status and disables it. Two more control bits drive the timer-2 gate and decide whether the timer-2 output reaches the speaker.

Host accesses use a plain strobe interface. `io_sel` is the address match, `io_wr` and `io_rd` are the write and read strobes, and data travels on an 8-bit bus. Writes take effect at the rising clock edge. Read data is combinational while a read is selected.

Top module: `sysctl_nmi_port`

## Requirements
- R1: After reset the control nibble (bits 3:0) is 4'hF, both status bits and the refresh toggle bit are 0, `nmi_req` is 0 and `tmr2_gate` is 1. With `tmr2_out` at 0, a read returns 8'h0F.
- R2: A write (`io_sel` and `io_wr` high at a rising edge) stores data bits 3:0 into control bits 3:0, and reads return them. Data bits 7:4 of a write have no effect on any read bit.
- R3: Read bit 7 (system-error status) becomes 1 at the first rising edge where `serr_n` is sampled 0 after having been sampled 1, provided control bit 2 is 0 after that edge. A one-cycle low pulse is enough.
- R4: Read bit 6 (channel-check status) becomes 1 at any rising edge where `iochk_n` is sampled 0, provided control bit 3 is 0 after that edge.
- R5: A set status bit stays 1 after its input returns inactive. It is cleared only by an edge after which its control bit (2 for bit 7, 3 for bit 6) is 1. While that control bit is 1 the status bit is held at 0 and ignores events.
- R6: `nmi_req` equals the OR of read bits 7 and 6 as they stood one clock earlier.
- R7: Read bit 5 equals the present level of `tmr2_out`, with no clock delay.
- R8: Read bit 4 inverts at every rising edge where `rfsh_done` is 1 and holds otherwise.
- R9: `spkr_out` equals `tmr2_out` AND control bit 1, combinationally.
- R10: `tmr2_gate` equals control bit 0.
- R11: `rd_data` is 8'h00 whenever `io_sel` and `io_rd` are not both 1.
- R12: When a write that sets a source's control bit to 1 coincides with an event on that source, the status bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 1 | Address match for this port |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data (zero when not read-selected) |
| serr_n | input | 1 | System-error pulse, active low, edge-detected |
| iochk_n | input | 1 | Channel-check line, active low, level-sensed |
| tmr2_out | input | 1 | Timer channel 2 output level |
| rfsh_done | input | 1 | One-cycle pulse per completed refresh cycle |
| nmi_req | output | 1 | Registered NMI request |
| tmr2_gate | output | 1 | Timer channel 2 gate |
| spkr_out | output | 1 | Speaker drive |

## Verification
A status flop that is stuck, or that misses the clear-wins rule, shows on read bits 7 and 6 in the cycle right after the edge that should have changed it. `nmi_req` then shows the same fault one cycle later. A broken edge detector on `serr_n` sets bit 7 again while the line stays low after a clear, or misses a one-cycle pulse. A wrong control flop shows at once on `tmr2_gate`, `spkr_out` or the low read nibble. A lost refresh toggle shows as a bit 4 that does not change on the next read after a pulse.

// File: rtl/nmi_port_pkg.sv
package nmi_port_pkg;

  localparam int DATA_W   = 8;
  localparam int CTRL_W   = 4;
  localparam int NUM_SRC  = 2;

  // Control bit positions (decoded by neighbouring logic)
  localparam int CB_TGATE = 0;
  localparam int CB_SPKEN = 1;
  localparam int CB_SERR  = 2;
  localparam int CB_IOCHK = 3;

  // Source indices
  localparam int SRC_SERR  = 0;
  localparam int SRC_IOCHK = 1;

  // Event detect: edge mode fires on a sampled high-to-low transition,
  // level mode fires whenever the active-low input is sampled low.
  function automatic logic src_event(input logic edge_mode,
                                     input logic prev_n,
                                     input logic now_n);
    if (edge_mode) return prev_n & ~now_n;
    return ~now_n;
  endfunction

  // Next status value: disable dominates, then set, else hold.
  function automatic logic stat_next(input logic cur,
                                     input logic dis,
                                     input logic evt);
    if (dis) return 1'b0;
    return cur | evt;
  endfunction

  // Assemble the read word from its parts.
  function automatic logic [DATA_W-1:0] pack_read(input logic serr_st,
                                                  input logic iochk_st,
                                                  input logic tmr2,
                                                  input logic tgl,
                                                  input logic [CTRL_W-1:0] ctrl);
    return {serr_st, iochk_st, tmr2, tgl, ctrl};
  endfunction

endpackage

// File: rtl/sysctl_ctrl_reg.sv
module sysctl_ctrl_reg
  import nmi_port_pkg::*;
#(
  parameter int                 W       = CTRL_W,
  parameter logic [CTRL_W-1:0]  RST_VAL = 4'hF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_q,
  output logic [W-1:0] ctrl_nxt
);

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_hit) ctrl_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= RST_VAL[W-1:0];
    else        ctrl_q <= ctrl_nxt;
  end

  // Control field only moves on a write
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctrl_q)); // R2

endmodule

// File: rtl/nmi_src_latch.sv
module nmi_src_latch
  import nmi_port_pkg::*;
#(
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_n,
  input  logic dis_nxt,
  output logic evt,
  output logic stat_q
);

  logic prev_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_n_q <= 1'b1;
    else        prev_n_q <= src_n;
  end

  assign evt = src_event(EDGE_MODE, prev_n_q, src_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_next(stat_q, dis_nxt, evt);
  end

  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dis_nxt |=> !stat_q); // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !dis_nxt) |=> stat_q); // R5

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !dis_nxt) |=> stat_q); // R3

endmodule

// File: rtl/rfsh_toggle.sv
module rfsh_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rfsh_done,
  output logic tgl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tgl_q <= 1'b0;
    else if (rfsh_done) tgl_q <= ~tgl_q;
  end

  AST_TGL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_done |=> (tgl_q != $past(tgl_q))); // R8

  AST_TGL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_done |=> $stable(tgl_q)); // R8

endmodule

// File: rtl/sysctl_nmi_port.sv
module sysctl_nmi_port
  import nmi_port_pkg::*;
#(
  parameter bit                SERR_EDGE  = 1'b1,
  parameter bit                IOCHK_EDGE = 1'b0,
  parameter logic [CTRL_W-1:0] CTRL_RST   = 4'hF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              serr_n,
  input  logic              iochk_n,
  input  logic              tmr2_out,
  input  logic              rfsh_done,
  output logic              nmi_req,
  output logic              tmr2_gate,
  output logic              spkr_out
);

  localparam logic [NUM_SRC-1:0] EDGE_SEL = {IOCHK_EDGE, SERR_EDGE};

  logic              wr_hit;
  logic              rd_en;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_nxt;
  logic [NUM_SRC-1:0] src_n;
  logic [NUM_SRC-1:0] src_dis;
  logic [NUM_SRC-1:0] src_evt;
  logic [NUM_SRC-1:0] src_stat;
  logic              tgl_q;
  logic              nmi_q;

  assign wr_hit = io_sel & io_wr;
  assign rd_en  = io_sel & io_rd;

  sysctl_ctrl_reg #(.W(CTRL_W), .RST_VAL(CTRL_RST)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (wr_hit),
    .wdata    (io_wdata[CTRL_W-1:0]),
    .ctrl_q   (ctrl_q),
    .ctrl_nxt (ctrl_nxt)
  );

  assign src_n[SRC_SERR]    = serr_n;
  assign src_n[SRC_IOCHK]   = iochk_n;
  assign src_dis[SRC_SERR]  = ctrl_nxt[CB_SERR];
  assign src_dis[SRC_IOCHK] = ctrl_nxt[CB_IOCHK];

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    nmi_src_latch #(.EDGE_MODE(EDGE_SEL[gi])) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_n   (src_n[gi]),
      .dis_nxt (src_dis[gi]),
      .evt     (src_evt[gi]),
      .stat_q  (src_stat[gi])
    );
  end

  rfsh_toggle u_tgl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rfsh_done (rfsh_done),
    .tgl_q     (tgl_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= |src_stat;
  end

  assign nmi_req   = nmi_q;
  assign tmr2_gate = ctrl_q[CB_TGATE];
  assign spkr_out  = tmr2_out & ctrl_q[CB_SPKEN];
  assign rd_data   = rd_en ? pack_read(src_stat[SRC_SERR], src_stat[SRC_IOCHK],
                                       tmr2_out, tgl_q, ctrl_q)
                           : '0;

  AST_NMI_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (nmi_req == $past(|src_stat))); // R6

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0)); // R11

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && io_wdata[CB_SERR]) |=> !src_stat[SRC_SERR]); // R12

endmodule

// File: tb/test_sysctl_nmi_port.sv
module test_sysctl_nmi_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_sel = 1'b1, io_wr = 1'b0, io_rd = 1'b1;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] rd_data;
  logic       serr_n = 1'b1, iochk_n = 1'b1, tmr2_out = 1'b0, rfsh_done = 1'b0;
  logic       nmi_req, tmr2_gate, spkr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysctl_nmi_port i_sysctl_nmi_port (
    .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .rd_data(rd_data), .serr_n(serr_n), .iochk_n(iochk_n),
    .tmr2_out(tmr2_out), .rfsh_done(rfsh_done), .nmi_req(nmi_req),
    .tmr2_gate(tmr2_gate), .spkr_out(spkr_out)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] wd;
    logic       serr_n;
    logic       iochk_n;
    logic       tmr2;
    logic       rfsh;
    logic [7:0] rd;
    logic       nmi;
    logic       spkr;
    logic       gate;
  } vec_t;

  // rd bits: 7 serr status, 6 iochk status, 5 timer2, 4 refresh toggle, 3:0 control
  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h20, 1'b0, 1'b0, 1'b0}, // R2 enable all
    '{1'b1, 8'h02, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA2, 1'b0, 1'b1, 1'b0}, // R3 R9 serr falls
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h92, 1'b1, 1'b0, 1'b0}, // R6 R8 R7
    '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'hF2, 1'b1, 1'b1, 1'b0}, // R4 R5
    '{1'b1, 8'hF4, 1'b1, 1'b1, 1'b0, 1'b0, 8'h54, 1'b1, 1'b0, 1'b0}, // R2 R5 clear serr
    '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h44, 1'b1, 1'b0, 1'b0}, // R5 disabled ignores
    '{1'b1, 8'h0D, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0D, 1'b1, 1'b0, 1'b1}, // R5 R10 clear iochk
    '{1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0D, 1'b0, 1'b0, 1'b1}, // R6 drops
    '{1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC1, 1'b0, 1'b0, 1'b1}, // R3 R4 enable+event
    '{1'b1, 8'h09, 1'b0, 1'b0, 1'b0, 1'b0, 8'h89, 1'b1, 1'b0, 1'b1}, // R5 iochk held off
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h89, 1'b1, 1'b0, 1'b1}  // R5 R3 no re-trigger
  };

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] wd, input logic s_n,
                      input logic i_n, input logic t2, input logic rf);
    @(negedge clk);
    io_wr = wr; io_wdata = wd; serr_n = s_n; iochk_n = i_n;
    tmr2_out = t2; rfsh_done = rf;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      step(VECS[v].wr, VECS[v].wd, VECS[v].serr_n, VECS[v].iochk_n,
           VECS[v].tmr2, VECS[v].rfsh);
      chk($sformatf("vec %0d R2 R3 R4 R5 R7 R8 rd_data", v), rd_data, VECS[v].rd);
      chk($sformatf("vec %0d R6 nmi_req", v), {7'd0, nmi_req}, {7'd0, VECS[v].nmi});
      chk($sformatf("vec %0d R9 spkr_out", v), {7'd0, spkr_out}, {7'd0, VECS[v].spkr});
      chk($sformatf("vec %0d R10 tmr2_gate", v), {7'd0, tmr2_gate}, {7'd0, VECS[v].gate});
    end

    // R1 reset state
    @(negedge clk);
    rst_n = 1'b0; io_wr = 1'b0; serr_n = 1'b1; iochk_n = 1'b1;
    tmr2_out = 1'b0; rfsh_done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset rd_data", rd_data, 8'h0F);
    chk("R1 reset nmi_req", {7'd0, nmi_req}, 8'd0);
    chk("R1 R10 reset tmr2_gate", {7'd0, tmr2_gate}, 8'd1);
    chk("R1 reset spkr_out", {7'd0, spkr_out}, 8'd0);

    // R7 R9 live timer level, no clock
    @(negedge clk); tmr2_out = 1'b1; #1;
    chk("R7 live timer bit", rd_data, 8'h2F);
    chk("R9 speaker follows timer", {7'd0, spkr_out}, 8'd1);

    // R11 no read strobe
    io_rd = 1'b0; #1;
    chk("R11 idle rd_data", rd_data, 8'h00);
    io_rd = 1'b1; io_sel = 1'b0; #1;
    chk("R11 unselected rd_data", rd_data, 8'h00);
    io_sel = 1'b1;

    // R3 single-cycle pulse captured and held (R5)
    step(1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3 one-cycle pulse bit7", {7'd0, rd_data[7]}, 8'd1);
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R5 pulse status held", {7'd0, rd_data[7]}, 8'd1);

    // R12 clear write coinciding with new falling edge
    step(1'b1, 8'h04, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R12 clear wins bit7", {7'd0, rd_data[7]}, 8'd0);
    chk("R6 nmi from prior status", {7'd0, nmi_req}, 8'd1);
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R6 nmi drops after clear", {7'd0, nmi_req}, 8'd0);

    // R4 level source: disabled then enabled while held low
    step(1'b1, 8'h0C, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R4 disabled iochk bit6", {7'd0, rd_data[6]}, 8'd0);
    step(1'b1, 8'h04, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R4 enabled held-low iochk bit6", {7'd0, rd_data[6]}, 8'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule